// File: doc/BRIEF.md
# Multiplexed Parallel Device Bus Timing Controller

This block is the master side of a multiplexed address/data parallel bus. It serves one chip select and drives an asynchronous NOR flash, SRAM or FPGA-style peripheral. A single-cycle request from inside the chip asks for a read or a write of one to eight beats. The controller then produces the address latch strobe, the active-low chip select, output enable and write enable, three low address bits, and a shared address/data bus with its own drive enable.

Every interval of the bus cycle is a count of clock ticks taken from two packed parameter words, one for reads and one for writes. The controller latches both words when it accepts a request, so a change to them cannot disturb a transfer that is already running. Reads return one data word per beat on a response strobe. Both reads and writes end with a done pulse once chip select has been released.

Top module: `devbus_ctrl`

## Requirements
- R1: After reset, `req_ready` is high and the bus is idle: chip select, output enable and write enable are high, the latch strobe is low and `bus_ad_oe` is low. A request is accepted in a cycle where `req_valid` and `req_ready` are both high. In the next cycle (the address cycle) the controller raises `bus_ale` for exactly one cycle, pulls `bus_cs_n` low, drives `req_addr[AW-1:3]` onto `bus_ad_o` with `bus_ad_oe` high, and drives `req_addr[2:0]` on `bus_a`.
- R2: Read-parameter bits [11:6] (first-access count F) place the first read sample F cycles after the address cycle's successor. Counting the address cycle as cycle 0, beat 0 is sampled at the end of cycle 1+F. Each sampled word appears on `rsp_rdata` with `rsp_valid` high for one cycle, in the cycle after its sample.
- R3: In a burst read, read-parameter bits [22:17] (next-beat count N) space consecutive samples max(N,1) cycles apart. `bus_a` for beat k is (req_addr[2:0] + k*bytes) mod 8, and it is held for the whole beat.
- R4: Read-parameter bits [16:12] (setup count S) make `bus_oe_n` go low S cycles after chip select goes low. When S is 0 they go low in the same cycle, and S never moves the first sample.
- R5: `bus_oe_n` returns high in the cycle after the last read sample. Read-parameter bits [27:23] (hold count H) keep chip select low for H further cycles after the last sample. `rsp_done` is high for one cycle, in the first cycle with chip select high again.
- R6: After the last read sample, read-parameter bits [5:0] (turn-off count T) keep the controller off the shared bus and `req_ready` low for T cycles. `req_ready` rises in cycle max(H,T)+1 after the last sample, and `bus_ad_oe` stays low for the whole read after the address cycle.
- R7: On a write, write-parameter bits [7:0] (delay A) put the first `bus_we_n` low cycle at cycle 1+A. Bits [15:8] (width L) keep it low for max(L,1) cycles, with that beat's data and low address held stable. Output enable stays high throughout.
- R8: Between write beats, write-parameter bits [23:16] (gap G) hold `bus_we_n` high for max(G,1) cycles. The next beat's address and data appear only in the last cycle of that gap. Chip select rises and `rsp_done` pulses in the cycle after the final low phase.
- R9: Read-parameter bits [31:30] set the data width. Value 2 selects 16 bits with an address step of 2 per beat. Any other value selects 8 bits with a step of 1: read data above bit 7 is returned as zero, and written data above bit 7 is driven as zero. Write data for beat k is `req_wdata[16k+15:16k]`.
- R10: The parameter words are captured on acceptance. Changes to `rd_param` or `wr_param` during a transfer have no effect on its timing or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_param | input | 32 | Packed read timing word |
| wr_param | input | 32 | Packed write timing word |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (19) | Start byte address |
| req_len | input | 3 | Beats minus one |
| req_wdata | input | MAXB*DW (128) | Write data, beat k in slice k |
| rsp_rdata | output | DW (16) | Read data word |
| rsp_valid | output | 1 | Read data strobe, one per beat |
| rsp_done | output | 1 | Transfer finished, chip select released |
| bus_ale | output | 1 | Address latch strobe |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_a | output | 3 | Low address bits |
| bus_ad_o | output | AW-3 (16) | Shared bus outbound value |
| bus_ad_oe | output | 1 | Shared bus drive enable |
| bus_ad_i | input | AW-3 (16) | Shared bus inbound value |

## Verification
Every bus result has a fixed cycle offset from the address cycle. The latch strobe comes at offset 0, beat samples at 1+F+k·max(N,1), with the data strobe one cycle after each sample. On writes, the low phases start at 1+A+k·(max(L,1)+max(G,1)). Release and done follow the last sample by H+1 cycles, and ready follows it by max(H,T)+1. The bench takes one snapshot of every output at each falling edge, so every registered change has settled before it is read. It indexes the snapshots from the address cycle and compares each one with a timeline it computes from the parameter fields. It scrambles both parameter words right after acceptance.

// File: rtl/devbus_ctrl.sv
module devbus_ctrl #(
  parameter int AW   = 19,
  parameter int DW   = 16,
  parameter int MAXB = 8,
  parameter int CW   = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [31:0]            rd_param,
  input  logic [31:0]            wr_param,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [AW-1:0]          req_addr,
  input  logic [$clog2(MAXB)-1:0] req_len,
  input  logic [MAXB*DW-1:0]     req_wdata,
  output logic [DW-1:0]          rsp_rdata,
  output logic                   rsp_valid,
  output logic                   rsp_done,
  output logic                   bus_ale,
  output logic                   bus_cs_n,
  output logic                   bus_oe_n,
  output logic                   bus_we_n,
  output logic [2:0]             bus_a,
  output logic [AW-4:0]          bus_ad_o,
  output logic                   bus_ad_oe,
  input  logic [AW-4:0]          bus_ad_i
);
  localparam int LA = 3;
  localparam int HW = AW - LA;
  localparam int BW = $clog2(MAXB);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_RD, S_HOLD, S_WWAIT, S_WLOW, S_WHIGH} st_t;

  st_t               st;
  logic [CW-1:0]     cnt;
  logic [4:0]        tick;
  logic [BW-1:0]     beat, len, idx;
  logic              wr, wide;
  logic [AW-1:0]     base;
  logic [MAXB*DW-1:0] wbuf;
  logic [27:0]       rp;
  logic [23:0]       wp;
  logic [5:0]        toff;
  logic [DW-1:0]     mask, wsel;
  logic [LA-1:0]     a_off;
  logic              last;
  logic              unused_fields;

  assign unused_fields = ^{rd_param[29:28], wr_param[31:24]};

  logic [5:0] p_toff, p_first, p_next;
  logic [4:0] p_setup, p_hold;
  logic [7:0] p_alewr, p_wlow, p_whigh;

  assign p_toff  = rp[5:0];
  assign p_first = rp[11:6];
  assign p_setup = rp[16:12];
  assign p_next  = rp[22:17];
  assign p_hold  = rp[27:23];
  assign p_alewr = wp[7:0];
  assign p_wlow  = wp[15:8];
  assign p_whigh = wp[23:16];

  function automatic logic [CW-1:0] less1(input logic [CW-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  assign mask  = wide ? {DW{1'b1}} : DW'(8'hFF);
  assign last  = (beat == len);
  assign idx   = (st == S_WHIGH && cnt == '0) ? beat + 1'b1 : beat;
  assign wsel  = wbuf[idx*DW +: DW];
  assign a_off = wide ? LA'({idx, 1'b0}) : LA'(idx);

  assign bus_a     = base[LA-1:0] + a_off;
  assign bus_ad_o  = (st == S_ADDR) ? base[AW-1:LA] : HW'(wsel & mask);
  assign bus_ad_oe = (st == S_ADDR) || (wr && (st == S_WWAIT || st == S_WLOW || st == S_WHIGH));
  assign bus_ale   = (st == S_ADDR);
  assign bus_cs_n  = (st == S_IDLE);
  assign bus_we_n  = (st != S_WLOW);
  assign bus_oe_n  = !(!wr && (st == S_ADDR || st == S_RD) && tick >= p_setup);
  assign req_ready = (st == S_IDLE) && (toff == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; tick <= '0; beat <= '0; len <= '0; wr <= 1'b0;
      wide <= 1'b0; base <= '0; wbuf <= '0; rp <= '0; wp <= '0; toff <= '0;
      rsp_rdata <= '0; rsp_valid <= 1'b0; rsp_done <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_done  <= 1'b0;
      if (toff != '0) toff <= toff - 1'b1;
      if (st != S_IDLE && tick != '1) tick <= tick + 1'b1;
      case (st)
        S_IDLE: if (req_valid && req_ready) begin
          st <= S_ADDR; tick <= '0; beat <= '0; len <= req_len; wr <= req_write;
          base <= req_addr; wbuf <= req_wdata;
          rp <= rd_param[27:0]; wp <= wr_param[23:0];
          wide <= (rd_param[31:30] == 2'd2);
        end
        S_ADDR: begin
          if (!wr) begin
            st <= S_RD; cnt <= CW'(p_first);
          end else if (p_alewr == '0) begin
            st <= S_WLOW; cnt <= less1(CW'(p_wlow));
          end else begin
            st <= S_WWAIT; cnt <= less1(CW'(p_alewr));
          end
        end
        S_RD: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            rsp_valid <= 1'b1;
            rsp_rdata <= bus_ad_i[DW-1:0] & mask;
            if (last) begin
              toff <= p_toff;
              if (p_hold == '0) begin
                st <= S_IDLE; rsp_done <= 1'b1;
              end else begin
                st <= S_HOLD; cnt <= less1(CW'(p_hold));
              end
            end else begin
              beat <= beat + 1'b1;
              cnt  <= less1(CW'(p_next));
            end
          end
        end
        S_HOLD: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin st <= S_IDLE; rsp_done <= 1'b1; end
        end
        S_WWAIT: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin st <= S_WLOW; cnt <= less1(CW'(p_wlow)); end
        end
        S_WLOW: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (last) begin st <= S_IDLE; rsp_done <= 1'b1; end
          else begin st <= S_WHIGH; cnt <= less1(CW'(p_whigh)); end
        end
        S_WHIGH: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin st <= S_WLOW; beat <= beat + 1'b1; cnt <= less1(CW'(p_wlow)); end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_ale_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> !bus_cs_n);
  a_r1_accept_to_ale: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> bus_ale);
  a_r5_done_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (bus_cs_n && !$past(bus_cs_n)));
  a_r5_oe_off_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe_n) |-> rsp_valid);
  a_r6_quiet_turnoff: assert property (@(posedge clk) disable iff (!rst_n)
    (toff != '0) |-> !bus_ad_oe);
  a_r6_ready_when_released: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> bus_cs_n);
  a_r7_we_low_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we_n && $past(!bus_we_n)) |-> ($stable(bus_ad_o) && $stable(bus_a)));
  a_r7_oe_we_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_oe_n && !bus_we_n));
endmodule

// File: tb/test_devbus_ctrl.sv
`timescale 1ns/1ps
module test_devbus_ctrl;
  localparam int LIM = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] rd_param = '0, wr_param = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [2:0] req_len = '0;
  logic [127:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_done, bus_ale, bus_cs_n, bus_oe_n, bus_we_n, bus_ad_oe;
  logic [15:0] rsp_rdata, bus_ad_o, bus_ad_i;
  logic [2:0] bus_a;
  logic [15:0] dev_tag = 16'h3C5A;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] dev_fn(input logic [2:0] a, input logic [15:0] tag);
    return tag ^ {a, 5'h0B, ~a, 5'h14};
  endfunction
  assign bus_ad_i = dev_fn(bus_a, dev_tag);

  devbus_ctrl i_devbus_ctrl (
    .clk(clk), .rst_n(rst_n), .rd_param(rd_param), .wr_param(wr_param),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_valid(rsp_valid), .rsp_done(rsp_done),
    .bus_ale(bus_ale), .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
    .bus_a(bus_a), .bus_ad_o(bus_ad_o), .bus_ad_oe(bus_ad_oe), .bus_ad_i(bus_ad_i));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  bit r_sig[8][LIM];
  logic [15:0] r_ad[LIM], r_rd[LIM];
  logic [2:0] r_a[LIM];

  bit e_wr, e_wide;
  int e_B, e_S, e_L, e_H, e_T, e_s0, e_Nn, e_W0, e_Wl, e_P, e_E, e_a0;

  function automatic bit is_val(int w);
    int d = w - 1 - e_s0;
    return !e_wr && d >= 0 && d % e_Nn == 0 && d / e_Nn < e_B;
  endfunction
  function automatic bit we_low(int w);
    int d = w - e_W0;
    return e_wr && d >= 0 && d % e_P < e_Wl && d / e_P < e_B;
  endfunction
  function automatic bit xp(int kind, int w);
    int rl = (e_L + 1 + e_H > e_L + 1 + e_T) ? e_L + 1 + e_H : e_L + 1 + e_T;
    case (kind)
      0: return w == 0;
      1: return e_wr ? (w > e_E) : (w > e_L + e_H);
      2: return e_wr ? 1'b1 : !(w >= e_S && w <= e_L);
      3: return !we_low(w);
      4: return is_val(w);
      5: return w == (e_wr ? e_E + 1 : e_L + 1 + e_H);
      6: return w >= (e_wr ? e_E + 1 : rl);
      default: return w == 0 || (e_wr && w <= e_E);
    endcase
  endfunction
  function automatic logic [2:0] exp_a(int k);
    return 3'(e_a0 + k * (e_wide ? 2 : 1));
  endfunction

  task automatic cmp_tl(input int kind, input string tag, input string nm);
    int bad = -1;
    for (int w = 0; w < LIM; w++)
      if (bad < 0 && r_sig[kind][w] != xp(kind, w)) bad = w;
    chk(bad < 0, tag, {nm, " timeline (actual/expected at first mismatch offset)"},
        bad < 0 ? 0 : longint'(r_sig[kind][bad]), bad < 0 ? 0 : longint'(xp(kind, bad)));
    if (bad >= 0) $display("      mismatch offset %0d", bad);
  endtask

  task automatic run(input bit w_r, input logic [18:0] addr, input int lenm1,
                     input logic [127:0] wd, input logic [31:0] rp, input logic [31:0] wp);
    logic [15:0] msk;
    int k, F, N, A, Wl, Wh;
    @(negedge clk);
    rd_param = rp; wr_param = wp; req_write = w_r; req_addr = addr;
    req_len = 3'(lenm1); req_wdata = wd; dev_tag = 16'($urandom); req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rd_param = $urandom; wr_param = $urandom;   // R10: must not matter now
    for (int w = 0; w < LIM; w++) begin
      r_sig[0][w] = bus_ale;  r_sig[1][w] = bus_cs_n; r_sig[2][w] = bus_oe_n;
      r_sig[3][w] = bus_we_n; r_sig[4][w] = rsp_valid; r_sig[5][w] = rsp_done;
      r_sig[6][w] = req_ready; r_sig[7][w] = bus_ad_oe;
      r_ad[w] = bus_ad_o; r_rd[w] = rsp_rdata; r_a[w] = bus_a;
      @(negedge clk);
    end
    e_wr = w_r; e_wide = (rp[31:30] == 2'd2); e_B = lenm1 + 1; e_a0 = int'(addr[2:0]);
    F = int'(rp[11:6]); N = int'(rp[22:17]); e_S = int'(rp[16:12]);
    e_H = int'(rp[27:23]); e_T = int'(rp[5:0]);
    e_Nn = (N == 0) ? 1 : N; e_s0 = 1 + F; e_L = e_s0 + (e_B - 1) * e_Nn;
    A = int'(wp[7:0]); Wl = int'(wp[15:8]); Wh = int'(wp[23:16]);
    e_Wl = (Wl == 0) ? 1 : Wl; e_P = e_Wl + ((Wh == 0) ? 1 : Wh);
    e_W0 = 1 + A; e_E = e_W0 + (e_B - 1) * e_P + e_Wl - 1;
    msk = e_wide ? 16'hFFFF : 16'h00FF;

    cmp_tl(0, "R1", "ale");
    chk(r_sig[7][0] && r_ad[0] == addr[18:3] && r_a[0] == addr[2:0], "R1",
        "address cycle ad/a", {r_ad[0], 1'b0, r_a[0]}, {addr[18:3], 1'b0, addr[2:0]});
    cmp_tl(1, "R5,R10", "cs_n");
    cmp_tl(5, "R5", "done");
    cmp_tl(6, "R6", "ready");
    cmp_tl(7, w_r ? "R7" : "R6", "ad_oe");
    if (!w_r) begin
      cmp_tl(2, "R4,R5", "oe_n");
      cmp_tl(4, "R2", "rsp_valid");
      k = 0;
      for (int w = 0; w < LIM; w++) if (xp(4, w)) begin
        chk(r_rd[w] == (dev_fn(exp_a(k), dev_tag) & msk), e_wide ? "R3" : "R9",
            $sformatf("read beat %0d data", k), r_rd[w], dev_fn(exp_a(k), dev_tag) & msk);
        k++;
      end
    end else begin
      cmp_tl(3, "R7,R8", "we_n");
      cmp_tl(2, "R7", "oe_n");
      for (int b = 0; b < e_B; b++) begin
        int st = e_W0 + b * e_P;
        logic [15:0] xd = wd[b*16 +: 16] & msk;
        chk(r_ad[st] == xd && r_ad[st + e_Wl - 1] == xd && r_a[st] == exp_a(b),
            e_wide ? "R7" : "R9", $sformatf("write beat %0d data", b), r_ad[st], xd);
        if (b > 0) begin
          chk(r_ad[st - 1] == xd && r_a[st - 1] == exp_a(b), "R8",
              $sformatf("gap last tick beat %0d", b), r_ad[st - 1], xd);
          if (e_P - e_Wl >= 2)
            chk(r_ad[st - 2] == (wd[(b-1)*16 +: 16] & msk), "R8",
                $sformatf("gap hold beat %0d", b - 1), r_ad[st - 2], wd[(b-1)*16 +: 16] & msk);
        end
      end
    end
  endtask

  function automatic logic [31:0] mk_rp(int wdt, int toff, int first, int setup, int nxt, int hold);
    return {2'(wdt), 2'($urandom), 5'(hold), 6'(nxt), 5'(setup), 6'(first), 6'(toff)};
  endfunction
  function automatic logic [31:0] mk_wp(int alewr, int lo, int hi);
    return {7'($urandom), 1'($urandom), 8'(hi), 8'(lo), 8'(alewr)};
  endfunction
  function automatic logic [127:0] rnd_wd();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && bus_cs_n && bus_oe_n && bus_we_n && !bus_ale && !bus_ad_oe
        && !rsp_valid && !rsp_done, "R1", "reset state",
        {req_ready, bus_cs_n, bus_oe_n, bus_we_n, bus_ale, bus_ad_oe, rsp_valid, rsp_done},
        8'b1111_0000);
    run(0, 19'h12345, 0, '0, mk_rp(2, 0, 0, 0, 0, 0), '0);
    run(0, 19'h00006, 7, '0, mk_rp(2, 0, 0, 0, 0, 0), '0);
    run(0, 19'h7FFF3, 3, '0, mk_rp(1, 7, 5, 3, 2, 2), '0);
    run(0, 19'h0A0A1, 2, '0, mk_rp(2, 20, 2, 0, 3, 1), '0);
    run(0, 19'h0A0A2, 1, '0, mk_rp(0, 3, 1, 2, 1, 6), '0);
    run(1, 19'h01234, 2, rnd_wd(), mk_rp(2, 0, 0, 0, 0, 0), mk_wp(0, 0, 0));
    run(1, 19'h55555, 3, rnd_wd(), mk_rp(1, 0, 0, 0, 0, 0), mk_wp(2, 3, 2));
    run(1, 19'h2AAAE, 7, rnd_wd(), mk_rp(2, 0, 0, 0, 0, 0), mk_wp(1, 1, 4));
    for (int i = 0; i < 40; i++) begin
      if ($urandom % 2 == 1)
        run(1, 19'($urandom), int'($urandom % 8), rnd_wd(),
            mk_rp(int'($urandom % 4), 0, 0, 0, 0, 0),
            mk_wp(int'($urandom % 7), int'($urandom % 7), int'($urandom % 7)));
      else
        run(0, 19'($urandom), int'($urandom % 8), '0,
            mk_rp(int'($urandom % 4), int'($urandom % 21), int'($urandom % 13),
                  int'($urandom % 11), int'($urandom % 9), int'($urandom % 7)), '0);
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d (cycles)", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule